// File: doc/BRIEF.md
# IR Carrier Meter

This block watches a raw infrared input that still carries its modulation. It measures the carrier in units of an external timebase enable, normally one pulse every 500 ns. For each complete carrier cycle it counts two values: the ticks from one rising edge to the next, and the ticks from that rising edge to the falling edge that follows. Both counts are published together in a pair of registers, and a valid flag sits in the top bit of the period word. The host derives the frequency as 2 MHz divided by the period count and the duty cycle as the high count times 100 divided by the period count. A reading with a clear flag or a zero count means that no measurement is available.

A minimum-period input rejects edges that come too close together. A separate envelope tracker turns the carrier into a demodulated level. The level is high while rising edges keep arriving, and it drops once the gap since the last rising edge exceeds twice the last published period. Measurement and demodulation are enabled independently.

The measuring machine has states IDLE, ARM, HIGH and LOW. IDLE goes to ARM when measuring is enabled. ARM goes to HIGH on a rising edge and starts the count. HIGH goes to LOW on a falling edge and captures the high count. LOW goes to HIGH on a rising edge, which publishes the period if it is accepted and restarts the count. HIGH or LOW goes back to ARM on overflow, which is a tick arriving while the count is already at its ceiling. Any state goes to IDLE when measuring is disabled. The envelope machine has states OFF and ON. OFF goes to ON on a rising edge while demodulation is enabled. ON stays ON on each rising edge. ON goes to OFF on a gap timeout or when demodulation is disabled.

Top module: `ircm_carrier_meter`

## Requirements
- R1: After reset, period_word, high_word, meas_valid and demod_out are all 0.
- R2: The period count is the number of tick enables from one accepted rising edge of ir_raw up to the next. It appears in period_word bits [6:0]. Bit 7 of period_word is the valid flag, equal to meas_valid.
- R3: high_word holds the number of tick enables from that same rising edge to the following falling edge. It is published in the same cycle as the period it belongs to, and it never exceeds that period.
- R4: A publication sets meas_valid. period_rd clears meas_valid on the next clock edge when no publication happens in that cycle. If a publication and period_rd fall in the same cycle, the new values are shown with the flag set. Without a read, the flag and the values are held.
- R5: A period count below min_period, or a count of zero, is not published. The registers and the flag stay unchanged.
- R6: A period or high time longer than 127 ticks is not published. The machine re-arms, and the next full carrier cycle is measured normally. A period of exactly 127 ticks is published.
- R7: Only clock cycles that carry a tick enable are counted. With one tick every second clock, a 20-clock period with 8 clocks high reads as 10 and 4.
- R8: While meas_en is low, no publication happens and the registers are held.
- R9: While demod_en is high, demod_out rises after a rising edge on ir_raw. It stays high while rising edges arrive. It falls once more than twice the last published period (in ticks) passes with no rising edge. Before any publication the limit is twice 127 ticks.
- R10: While demod_en is low, demod_out is 0 whatever ir_raw does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase enable, one pulse per 500 ns |
| ir_raw | input | 1 | Raw, still modulated IR input (asynchronous) |
| meas_en | input | 1 | Enables carrier measurement |
| demod_en | input | 1 | Enables the demodulated envelope |
| min_period | input | 7 | Smallest period count that is published |
| period_rd | input | 1 | Host read strobe; clears the valid flag |
| period_word | output | 8 | {valid, period count} |
| high_word | output | 7 | High-time count of the published cycle |
| meas_valid | output | 1 | Valid flag (same as period_word[7]) |
| demod_out | output | 1 | Demodulated carrier envelope |

## Verification
The host read that clears the flag and a fresh publication at a rising edge can fall in the same clock cycle. The bench provokes this by holding period_rd high for a whole carrier burst, so that every publication coincides with a read. It then counts the sampling points at which the flag is seen set. Exactly one such point must appear per published cycle, and it must show the new period and high counts. A design that lets the read win shows none. A design that ignores the read shows the flag stuck high.

// File: rtl/ircm_pkg.sv
package ircm_pkg;

    // States of the carrier measuring machine
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_ARM  = 2'd1,
        MS_HIGH = 2'd2,
        MS_LOW  = 2'd3
    } meas_state_t;

    // States of the envelope (demodulation) machine
    typedef enum logic {
        ENV_OFF = 1'b0,
        ENV_ON  = 1'b1
    } env_state_t;

endpackage

// File: rtl/ircm_edge.sv
// Synchronises the raw IR line and flags its rising and falling edges.
module ircm_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int SW = SYNC_STAGES + 1;

    logic [SW-1:0] shr_q;
    logic          cur;
    logic          prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shr_q <= '0;
        end else begin
            shr_q <= {shr_q[SW-2:0], din};
        end
    end

    assign cur  = shr_q[SYNC_STAGES-1];
    assign prev = shr_q[SYNC_STAGES];
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

endmodule

// File: rtl/ircm_meas.sv
// Period and high-time measuring machine with publish registers.
module ircm_meas
    import ircm_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rise,
    input  logic          fall,
    input  logic          en,
    input  logic [CW-1:0] thr,
    input  logic          rd_clr,
    output logic [CW-1:0] period_q,
    output logic [CW-1:0] high_q,
    output logic          valid_q,
    output logic [CW-1:0] last_q
);
    localparam logic [CW-1:0] MAXC = '1;
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    meas_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] hcap_q;
    logic          ovf;
    logic          restart;
    logic          counting;
    logic          pub;

    // A tick arriving while the count already sits at its ceiling
    assign ovf      = tick && (cnt_q == MAXC);
    assign counting = (state_q == MS_HIGH) || (state_q == MS_LOW);
    assign restart  = rise && ((state_q == MS_ARM) || (state_q == MS_LOW));
    assign pub      = en && rise && (state_q == MS_LOW)
                      && (cnt_q >= thr) && (cnt_q != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (en) state_d = MS_ARM;
            MS_ARM:  if (rise) state_d = MS_HIGH;
            MS_HIGH: begin
                if (fall)     state_d = MS_LOW;
                else if (ovf) state_d = MS_ARM;
            end
            MS_LOW: begin
                if (rise)     state_d = MS_HIGH;
                else if (ovf) state_d = MS_ARM;
            end
        endcase
        if (!en) state_d = MS_IDLE;
    end

    // Tick counter and high-time capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hcap_q <= '0;
        end else begin
            if (restart) begin
                cnt_q <= tick ? ONE : '0;
            end else if (counting && tick && (cnt_q != MAXC)) begin
                cnt_q <= cnt_q + ONE;
            end
            if ((state_q == MS_HIGH) && fall) begin
                hcap_q <= cnt_q;
            end
        end
    end

    // Output (publish) registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            high_q   <= '0;
            valid_q  <= 1'b0;
            last_q   <= MAXC;
        end else if (pub) begin
            period_q <= cnt_q;
            high_q   <= hcap_q;
            valid_q  <= 1'b1;
            last_q   <= cnt_q;
        end else if (rd_clr) begin
            valid_q  <= 1'b0;
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !(rise && state_q == MS_LOW)) |=> !valid_q); // R4

    AST_NONZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (period_q != '0)); // R5

    AST_HIGH_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (high_q <= period_q)); // R3

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == MS_IDLE)); // R8

endmodule

// File: rtl/ircm_env.sv
// Envelope tracker: high while carrier rising edges keep arriving.
module ircm_env
    import ircm_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rise,
    input  logic          dm_en,
    input  logic [CW-1:0] last_period,
    output logic          demod
);
    localparam int GW = CW + 2;
    localparam logic [GW-1:0] GONE = {{(GW-1){1'b0}}, 1'b1};

    env_state_t    state_q, state_d;
    logic [GW-1:0] gap_q;
    logic [GW-1:0] limit;
    logic          timeout;

    assign limit   = {1'b0, last_period, 1'b0};
    assign timeout = (gap_q > limit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENV_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENV_OFF: if (dm_en && rise) state_d = ENV_ON;
            ENV_ON: begin
                if (!dm_en)        state_d = ENV_OFF;
                else if (rise)     state_d = ENV_ON;
                else if (timeout)  state_d = ENV_OFF;
            end
        endcase
    end

    // Gap counter in ticks since the last rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (rise) begin
            gap_q <= tick ? GONE : '0;
        end else if (tick && !(&gap_q)) begin
            gap_q <= gap_q + GONE;
        end
    end

    // Output process
    always_comb begin
        demod = (state_q == ENV_ON);
    end

    AST_DEMOD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !dm_en |=> !demod); // R10

endmodule

// File: rtl/ircm_carrier_meter.sv
// Top: carrier period / high-time meter with demodulated envelope.
module ircm_carrier_meter #(
    parameter int CW          = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ir_raw,
    input  logic          meas_en,
    input  logic          demod_en,
    input  logic [CW-1:0] min_period,
    input  logic          period_rd,
    output logic [CW:0]   period_word,
    output logic [CW-1:0] high_word,
    output logic          meas_valid,
    output logic          demod_out
);
    logic          rise;
    logic          fall;
    logic [CW-1:0] period_cnt;
    logic [CW-1:0] last_period;

    ircm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ir_raw),
        .rise (rise),
        .fall (fall)
    );

    ircm_meas #(.CW(CW)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rise    (rise),
        .fall    (fall),
        .en      (meas_en),
        .thr     (min_period),
        .rd_clr  (period_rd),
        .period_q(period_cnt),
        .high_q  (high_word),
        .valid_q (meas_valid),
        .last_q  (last_period)
    );

    ircm_env #(.CW(CW)) u_env (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rise       (rise),
        .dm_en      (demod_en),
        .last_period(last_period),
        .demod      (demod_out)
    );

    assign period_word = {meas_valid, period_cnt};

endmodule

// File: tb/sim_ircm_carrier_meter.sv
module sim_ircm_carrier_meter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       ir_raw = 1'b0;
    logic       meas_en = 1'b0;
    logic       demod_en = 1'b0;
    logic [6:0] min_period = 7'd4;
    logic       period_rd = 1'b0;
    logic [7:0] period_word;
    logic [6:0] high_word;
    logic       meas_valid;
    logic       demod_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    bit tick_half = 1'b0;
    bit watch_on = 1'b0;
    int watch_hits = 0;
    int watch_p = 0;
    int watch_h = 0;

    int    exp_q[$];
    string req_q[$];

    ircm_carrier_meter u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ir_raw(ir_raw),
        .meas_en(meas_en), .demod_en(demod_en), .min_period(min_period),
        .period_rd(period_rd), .period_word(period_word),
        .high_word(high_word), .meas_valid(meas_valid), .demod_out(demod_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Tick generator: every clock, or every second clock
    initial begin
        forever begin
            @(negedge clk);
            tick = tick_half ? ~tick : 1'b1;
        end
    end

    // Monitor: pops expected items as publications appear, then reads
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && meas_valid && !period_rd) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected publication", period_word, 0);
                end else begin
                    int    e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(period_word == {1'b1, e[13:7]}, r, "period word",
                        period_word, {1'b1, e[13:7]});
                    chk(high_word == e[6:0], r, "high word", high_word, e[6:0]);
                end
                period_rd = 1'b1;
                @(negedge clk);
                period_rd = 1'b0;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        if (watch_on && meas_valid) begin
            watch_hits++;
            chk(period_word == {1'b1, 7'(watch_p)}, "R4", "coincident period",
                period_word, {1'b1, 7'(watch_p)});
            chk(high_word == 7'(watch_h), "R4", "coincident high",
                high_word, watch_h);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    // Driver: n carrier cycles of p clocks with h clocks high
    task automatic carrier(input int n, input int p, input int h,
                           input bit push, input int ep, input int eh,
                           input string req);
        for (int i = 0; i < n; i++) begin
            if (push && i > 0) begin
                exp_q.push_back((ep << 7) | eh);
                req_q.push_back(req);
            end
            ir_raw = 1'b1;
            for (int k = 0; k < h; k++) step();
            ir_raw = 1'b0;
            for (int k = 0; k < p - h; k++) step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R1: reset state
        idle(4);
        chk(period_word == 8'd0, "R1", "period word after reset", period_word, 0);
        chk(high_word == 7'd0, "R1", "high word after reset", high_word, 0);
        chk(meas_valid == 1'b0, "R1", "valid after reset", meas_valid, 0);
        chk(demod_out == 1'b0, "R1", "demod after reset", demod_out, 0);
        rst_n = 1'b1;
        idle(3);

        meas_en = 1'b1;
        mon_on = 1'b1;
        min_period = 7'd4;

        // R2 / R3: basic carrier patterns
        carrier(5, 20, 8, 1'b1, 20, 8, "R2");
        idle(300);
        carrier(4, 13, 3, 1'b1, 13, 3, "R3");
        idle(300);

        // R5: threshold rejects short periods, accepts the boundary
        min_period = 7'd16;
        carrier(4, 12, 4, 1'b0, 0, 0, "R5");
        idle(5);
        chk(meas_valid == 1'b0, "R5", "short period rejected", meas_valid, 0);
        chk(period_word[6:0] == 7'd13, "R5", "held after reject",
            period_word[6:0], 13);
        idle(300);
        carrier(3, 16, 6, 1'b1, 16, 6, "R5");
        idle(300);
        min_period = 7'd4;

        // R6: too-long period is dropped, 127 exactly is published
        carrier(2, 140, 10, 1'b0, 0, 0, "R6");
        idle(300);
        chk(meas_valid == 1'b0, "R6", "overlong period dropped", meas_valid, 0);
        carrier(3, 127, 60, 1'b1, 127, 60, "R6");
        idle(300);

        // R7: one tick every second clock
        tick_half = 1'b1;
        carrier(4, 20, 8, 1'b1, 10, 4, "R7");
        idle(300);
        tick_half = 1'b0;
        idle(300);

        // R4: publication and read in the same cycle
        mon_on = 1'b0;
        idle(4);
        period_rd = 1'b1;
        watch_p = 16;
        watch_h = 5;
        watch_hits = 0;
        watch_on = 1'b1;
        carrier(3, 16, 5, 1'b0, 0, 0, "R4");
        idle(4);
        watch_on = 1'b0;
        period_rd = 1'b0;
        chk(watch_hits == 2, "R4", "flag seen once per publication", watch_hits, 2);
        idle(300);

        // R4: flag held without read, cleared by a single read
        carrier(2, 20, 8, 1'b0, 0, 0, "R4");
        idle(30);
        chk(meas_valid == 1'b1, "R4", "flag held without read", meas_valid, 1);
        period_rd = 1'b1;
        step();
        period_rd = 1'b0;
        chk(meas_valid == 1'b0, "R4", "flag cleared by read", meas_valid, 0);
        chk(period_word == 8'd20, "R4", "count kept after read", period_word, 20);
        idle(300);

        // R8: measuring disabled
        meas_en = 1'b0;
        carrier(3, 30, 8, 1'b0, 0, 0, "R8");
        idle(5);
        chk(meas_valid == 1'b0, "R8", "no publication while disabled", meas_valid, 0);
        chk(period_word == 8'd20, "R8", "period held while disabled", period_word, 20);
        chk(high_word == 7'd8, "R8", "high held while disabled", high_word, 8);
        meas_en = 1'b1;
        idle(300);

        // R9: envelope follows carrier, times out after twice the period
        mon_on = 1'b1;
        demod_en = 1'b1;
        idle(2);
        chk(demod_out == 1'b0, "R9", "envelope low before carrier", demod_out, 0);
        carrier(6, 20, 8, 1'b1, 20, 8, "R9");
        chk(demod_out == 1'b1, "R9", "envelope high after burst", demod_out, 1);
        idle(15);
        chk(demod_out == 1'b1, "R9", "envelope held inside limit", demod_out, 1);
        idle(20);
        chk(demod_out == 1'b0, "R9", "envelope dropped after limit", demod_out, 0);
        idle(300);

        // R10: envelope disabled
        demod_en = 1'b0;
        carrier(3, 20, 8, 1'b1, 20, 8, "R10");
        chk(demod_out == 1'b0, "R10", "envelope low while disabled", demod_out, 0);
        idle(300);

        chk(exp_q.size() == 0, "R2", "all expected publications seen",
            exp_q.size(), 0);
        report();
    end

endmodule